// File: doc/BRIEF.md
# Camera Function Command/Status Register

This block holds the combined command and status dword of an on-chip camera function's PCI-style configuration header. Configuration software reads and writes it through a simple port with per-byte enables. Reads return the assembled dword combinationally. Writes take effect on the next clock edge.

Three of the writable control bits do more than store a value. The interrupt-disable bit stops legacy INTx assert and deassert messages. The bus-master bit lets MSI requests through. The memory-enable bit allows the function to claim inbound memory reads and writes whose upper address bits match the base address it is given. Hardware sets three abort flags. Software clears each one by writing 1 to it. A live interrupt-status bit shows the OR, over all lanes, of the interrupt-enable vector ANDed with the interrupt-identification vector.

Top module: `cam_cmdsts_reg`

## Requirements
- R1: Bit 29 is set by `ev_ur`, bit 28 by `ev_ca` and bit 27 by `ev_in_ca`, one edge after the event. Each bit stays set until a write with byte lane 3 enabled carries a 1 in that bit. Writing a 0 leaves the bit unchanged.
- R2: Bit 20 always reads 1. Bits 31, 30, 26:21, 18:11, 9:3 except bit 2... precisely bits 9, 8, 7, 6, 5, 4, 3 and 0, always read 0, whatever is written to them.
- R3: Bit 19 equals the OR over all lanes of `irq_en & irq_id`, in the same cycle, and cannot be written.
- R4: Bit 10 is read/write and resets to 0. While it is 1 no INTx message is emitted. Bit 19 still shows the true condition.
- R5: The gated condition is the interrupt condition with bit 10 clear. `intx_assert_msg` pulses for one cycle after the edge at which the gated condition is 1 and no assert is outstanding. `intx_deassert_msg` pulses for one cycle after the edge at which the gated condition is 0 and an assert is outstanding. This includes the case where bit 10 is set while an assert is outstanding.
- R6: Bit 2 is read/write and resets to 0. `msi_req` pulses for one cycle after each edge at which the interrupt condition rises while bit 2 is 1. No pulse is produced while bit 2 is 0.
- R7: Bit 1 is read/write and resets to 0. `in_claim` is 1 in the same cycle when bit 1 is 1, `in_valid` is 1, `in_cmd` is 2'b01 (memory read) or 2'b10 (memory write), and `in_addr[31:22]` equals `bar_base[31:22]`. Otherwise it is 0.
- R8: Commands 2'b11 (I/O) and 2'b00 (none) are never claimed.
- R9: When an event and a write-1-to-clear hit the same error bit at the same edge, the bit ends up set.
- R10: A write updates only the writable bits inside enabled byte lanes. Bits 1 and 2 are in lane 0, bit 10 in lane 1, and bits 29:27 in lane 3.
- R11: After reset the register reads 0x00100000, ORed with bit 19 as given by R3, and no message, MSI or claim output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Assembled register value (combinational) |
| ev_ur | input | 1 | Unsupported-request completion received |
| ev_ca | input | 1 | Completer-abort completion received |
| ev_in_ca | input | 1 | Inbound request answered with completer abort |
| irq_en | input | IRQ_W | Interrupt-enable vector |
| irq_id | input | IRQ_W | Interrupt-identification vector |
| intx_assert_msg | output | 1 | One-cycle request to send an INTx assert message |
| intx_deassert_msg | output | 1 | One-cycle request to send an INTx deassert message |
| msi_req | output | 1 | One-cycle MSI request |
| in_valid | input | 1 | Inbound command valid |
| in_cmd | input | 2 | Inbound command: 00 none, 01 mem read, 10 mem write, 11 I/O |
| in_addr | input | 32 | Inbound address |
| bar_base | input | 32 | Memory base address register value |
| in_claim | output | 1 | Inbound command claimed |

## Verification
On every cycle the assertions check:
- that the constant bits hold their values;
- that the status bit mirrors the interrupt inputs;
- that INTx assert and deassert are never requested together, and that no assert follows a cycle in which bit 10 was 1;
- that MSI requests appear only when bus mastering was enabled;
- that claims appear only for memory commands while bit 1 is set;
- that an error event always leaves its flag set.

Only the bench's scenarios can show the rest:
- the exact timing of messages, including the deassert forced by disabling while an assert is outstanding;
- the effect of byte lanes;
- that a set wins over a clear in the same cycle;
- that address mismatches are refused.

// File: rtl/cmdsts_pkg.sv
package cmdsts_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_MRD  = 2'b01,
    CMD_MWR  = 2'b10,
    CMD_IO   = 2'b11
  } in_cmd_e;

  localparam int DW        = 32;
  localparam int BEW       = DW / 8;
  localparam int B_MSE     = 1;
  localparam int B_BME     = 2;
  localparam int B_INTDIS  = 10;
  localparam int B_ISTAT   = 19;
  localparam int B_CAP     = 20;
  localparam int B_E_INCA  = 27;
  localparam int B_E_CA    = 28;
  localparam int B_E_UR    = 29;
  localparam int NERR      = 3;
endpackage

// File: rtl/cmdsts_regs.sv
module cmdsts_regs
  import cmdsts_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [BEW-1:0]  be,
  input  logic [DW-1:0]   wdata,
  input  logic [NERR-1:0] err_set,   // [2]=ur [1]=ca [0]=inbound ca
  output logic            mse,
  output logic            bme,
  output logic            intdis,
  output logic [NERR-1:0] err
);
  localparam int LANE_MSE = B_MSE / 8;
  localparam int LANE_BME = B_BME / 8;
  localparam int LANE_DIS = B_INTDIS / 8;
  localparam int LANE_ERR = B_E_INCA / 8;

  logic            mse_d, bme_d, dis_d;
  logic [NERR-1:0] err_d;
  logic [NERR-1:0] clr;
  logic            ctl_en;

  assign ctl_en = wr;

  always_comb begin
    mse_d = mse;
    bme_d = bme;
    dis_d = intdis;
    if (ctl_en && be[LANE_MSE]) mse_d = wdata[B_MSE];
    if (ctl_en && be[LANE_BME]) bme_d = wdata[B_BME];
    if (ctl_en && be[LANE_DIS]) dis_d = wdata[B_INTDIS];
  end

  always_comb begin
    clr   = (wr && be[LANE_ERR]) ? wdata[B_E_UR:B_E_INCA] : '0;
    err_d = (err & ~clr) | err_set;  // hardware set has priority
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mse    <= 1'b0;
      bme    <= 1'b0;
      intdis <= 1'b0;
    end else if (ctl_en) begin
      mse    <= mse_d;
      bme    <= bme_d;
      intdis <= dis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= '0;
    else        err <= err_d;
  end
endmodule

// File: rtl/cmdsts_irq.sv
module cmdsts_irq #(
  parameter int IRQ_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] ier,
  input  logic [IRQ_W-1:0] iir,
  input  logic             intdis,
  input  logic             bme,
  output logic             istat,
  output logic             asrt_msg,
  output logic             deas_msg,
  output logic             msi
);
  logic line_q, line_d;
  logic cond_q;
  logic asrt_d, deas_d, msi_d;
  logic gated;

  assign istat = |(ier & iir);
  assign gated = istat & ~intdis;

  always_comb begin
    line_d = gated;
    asrt_d = gated & ~line_q;
    deas_d = ~gated & line_q;
    msi_d  = istat & ~cond_q & bme;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q   <= 1'b0;
      cond_q   <= 1'b0;
      asrt_msg <= 1'b0;
      deas_msg <= 1'b0;
      msi      <= 1'b0;
    end else begin
      line_q   <= line_d;
      cond_q   <= istat;
      asrt_msg <= asrt_d;
      deas_msg <= deas_d;
      msi      <= msi_d;
    end
  end
endmodule

// File: rtl/cmdsts_dec.sv
module cmdsts_dec
  import cmdsts_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MATCH_LSB = 22
) (
  input  logic              mse,
  input  logic              valid,
  input  logic [1:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] bar,
  output logic              claim
);
  logic is_mem, hit;

  always_comb begin
    is_mem = (cmd == CMD_MRD) || (cmd == CMD_MWR);
    hit    = (addr[ADDR_W-1:MATCH_LSB] == bar[ADDR_W-1:MATCH_LSB]);
    claim  = mse & valid & is_mem & hit;
  end
endmodule

// File: rtl/cam_cmdsts_reg.sv
module cam_cmdsts_reg
  import cmdsts_pkg::*;
#(
  parameter int IRQ_W     = 4,
  parameter int ADDR_W    = 32,
  parameter int MATCH_LSB = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              ev_ur,
  input  logic              ev_ca,
  input  logic              ev_in_ca,
  input  logic [IRQ_W-1:0]  irq_en,
  input  logic [IRQ_W-1:0]  irq_id,
  output logic              intx_assert_msg,
  output logic              intx_deassert_msg,
  output logic              msi_req,
  input  logic              in_valid,
  input  logic [1:0]        in_cmd,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [ADDR_W-1:0] bar_base,
  output logic              in_claim
);
  logic            mse, bme, intdis, istat;
  logic [NERR-1:0] err;

  cmdsts_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .be      (cfg_be),
    .wdata   (cfg_wdata),
    .err_set ({ev_ur, ev_ca, ev_in_ca}),
    .mse     (mse),
    .bme     (bme),
    .intdis  (intdis),
    .err     (err)
  );

  cmdsts_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .ier      (irq_en),
    .iir      (irq_id),
    .intdis   (intdis),
    .bme      (bme),
    .istat    (istat),
    .asrt_msg (intx_assert_msg),
    .deas_msg (intx_deassert_msg),
    .msi      (msi_req)
  );

  cmdsts_dec #(.ADDR_W(ADDR_W), .MATCH_LSB(MATCH_LSB)) u_dec (
    .mse   (mse),
    .valid (in_valid),
    .cmd   (in_cmd),
    .addr  (in_addr),
    .bar   (bar_base),
    .claim (in_claim)
  );

  always_comb begin
    cfg_rdata                   = '0;
    cfg_rdata[B_MSE]            = mse;
    cfg_rdata[B_BME]            = bme;
    cfg_rdata[B_INTDIS]         = intdis;
    cfg_rdata[B_ISTAT]          = istat;
    cfg_rdata[B_CAP]            = 1'b1;
    cfg_rdata[B_E_UR:B_E_INCA]  = err;
  end
endmodule

// File: rtl/cam_cmdsts_chk.sv
module cam_cmdsts_chk #(
  parameter int IRQ_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      cfg_rdata,
  input logic             ev_ur,
  input logic             ev_ca,
  input logic             ev_in_ca,
  input logic [IRQ_W-1:0] irq_en,
  input logic [IRQ_W-1:0] irq_id,
  input logic             intx_assert_msg,
  input logic             intx_deassert_msg,
  input logic             msi_req,
  input logic             in_valid,
  input logic [1:0]       in_cmd,
  input logic             in_claim
);
  // R2
  const_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[20] && ((cfg_rdata & 32'hC7E7_FBF9) == 32'h0));

  // R3
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[19] == |(irq_en & irq_id));

  // R5
  intx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(intx_assert_msg && intx_deassert_msg));

  // R4
  intx_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[10] |=> !intx_assert_msg);

  // R6
  msi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[2] |=> !msi_req);

  // R7
  claim_mse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_claim |-> (cfg_rdata[1] && in_valid));

  // R8
  claim_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_claim |-> (in_cmd == 2'b01 || in_cmd == 2'b10));

  // R1 R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ur || ev_ca || ev_in_ca) |=>
      ((!$past(ev_ur) || cfg_rdata[29]) && (!$past(ev_ca) || cfg_rdata[28]) &&
       (!$past(ev_in_ca) || cfg_rdata[27])));
endmodule

bind cam_cmdsts_reg cam_cmdsts_chk #(.IRQ_W(IRQ_W)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cfg_rdata         (cfg_rdata),
  .ev_ur             (ev_ur),
  .ev_ca             (ev_ca),
  .ev_in_ca          (ev_in_ca),
  .irq_en            (irq_en),
  .irq_id            (irq_id),
  .intx_assert_msg   (intx_assert_msg),
  .intx_deassert_msg (intx_deassert_msg),
  .msi_req           (msi_req),
  .in_valid          (in_valid),
  .in_cmd            (in_cmd),
  .in_claim          (in_claim)
);

// File: tb/test_cam_cmdsts_reg.sv
`timescale 1ns/1ps
module test_cam_cmdsts_reg;
  localparam int IRQ_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [3:0] cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic ev_ur = 1'b0, ev_ca = 1'b0, ev_in_ca = 1'b0;
  logic [IRQ_W-1:0] irq_en = '0, irq_id = '0;
  logic intx_assert_msg, intx_deassert_msg, msi_req;
  logic in_valid = 1'b0;
  logic [1:0] in_cmd = 2'b00;
  logic [31:0] in_addr = '0, bar_base = 32'hA5C0_0000;
  logic in_claim;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  cam_cmdsts_reg #(.IRQ_W(IRQ_W)) i_cam_cmdsts_reg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_ur(ev_ur),
    .ev_ca(ev_ca), .ev_in_ca(ev_in_ca), .irq_en(irq_en), .irq_id(irq_id),
    .intx_assert_msg(intx_assert_msg), .intx_deassert_msg(intx_deassert_msg),
    .msi_req(msi_req), .in_valid(in_valid), .in_cmd(in_cmd),
    .in_addr(in_addr), .bar_base(bar_base), .in_claim(in_claim)
  );

  // behavioural reference state
  bit m_mse, m_bme, m_dis;
  bit m_ur, m_ca, m_inca;
  bit m_line, m_prev, m_asrt, m_deas, m_msi;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_mse, m_bme, m_dis, m_ur, m_ca, m_inca} = '0;
      {m_line, m_prev, m_asrt, m_deas, m_msi} = '0;
    end else begin
      bit c, g;
      c = (irq_en & irq_id) != 0;
      g = c && !m_dis;
      m_asrt = g && !m_line;
      m_deas = !g && m_line;
      m_line = g;
      m_msi  = c && !m_prev && m_bme;
      m_prev = c;
      if (cfg_wr && cfg_be[3]) begin
        if (cfg_wdata[29]) m_ur = 0;
        if (cfg_wdata[28]) m_ca = 0;
        if (cfg_wdata[27]) m_inca = 0;
      end
      if (ev_ur) m_ur = 1;
      if (ev_ca) m_ca = 1;
      if (ev_in_ca) m_inca = 1;
      if (cfg_wr && cfg_be[0]) begin
        m_mse = cfg_wdata[1];
        m_bme = cfg_wdata[2];
      end
      if (cfg_wr && cfg_be[1]) m_dis = cfg_wdata[10];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare on every clock, half a period after the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit expc;
      expc = m_mse && in_valid && (in_cmd == 2'b01 || in_cmd == 2'b10) &&
             in_addr[31:22] == bar_base[31:22];
      chk("R1 err flags", {29'd0, cfg_rdata[29:27]}, {29'd0, m_ur, m_ca, m_inca});
      chk("R2 fixed bits", cfg_rdata & 32'hC7F7_FBF9, 32'h0010_0000);
      chk("R3 status", {31'd0, cfg_rdata[19]}, {31'd0, (irq_en & irq_id) != 0});
      chk("R4 intx disable", {31'd0, cfg_rdata[10]}, {31'd0, m_dis});
      chk("R5 intx assert", {31'd0, intx_assert_msg}, {31'd0, m_asrt});
      chk("R5 intx deassert", {31'd0, intx_deassert_msg}, {31'd0, m_deas});
      chk("R6 bme", {31'd0, cfg_rdata[2]}, {31'd0, m_bme});
      chk("R6 msi", {31'd0, msi_req}, {31'd0, m_msi});
      chk("R7 mse", {31'd0, cfg_rdata[1]}, {31'd0, m_mse});
      chk("R7 R8 claim", {31'd0, in_claim}, {31'd0, expc});
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wcfg(input logic [3:0] be, input logic [31:0] d);
    step();
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
    step();
    cfg_wr = 1'b0; cfg_be = '0; cfg_wdata = '0;
  endtask

  task automatic cmd(input logic [1:0] c, input logic [31:0] a);
    in_valid = 1'b1; in_cmd = c; in_addr = a;
    step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset value", cfg_rdata, 32'h0010_0000);
    chk("R11 reset outputs", {29'd0, intx_assert_msg, msi_req, in_claim}, 32'd0);

    // R2 R10: writes to RO bits ignored; lane masking
    wcfg(4'hF, 32'hFFFF_FFFF & ~32'h3800_0000);
    wcfg(4'hF, 32'h0);
    wcfg(4'b0010, 32'h0000_0406);  // only bit 10 lane
    wcfg(4'b0001, 32'h0000_0406);  // bits 1,2
    wcfg(4'b0110, 32'h0000_0000);  // clears bit 10, leaves lane 0
    wcfg(4'h1, 32'h0);

    // R3 R5 interrupt edges, R6 with bme=0
    step(); irq_en = 4'b0101; irq_id = 4'b0010;
    step(); irq_id = 4'b0100;
    repeat (3) step();
    irq_id = 4'b0000;
    repeat (3) step();

    // R6 with bme=1
    wcfg(4'h1, 32'h4);
    irq_id = 4'b0001; repeat (2) step();
    irq_id = 4'b0000; step();
    irq_id = 4'b0100; repeat (2) step();

    // R4 R5 disable while outstanding -> deassert, status still live
    wcfg(4'b0010, 32'h400);
    repeat (2) step();
    irq_id = 4'b0000; repeat (2) step();
    irq_id = 4'b0001; repeat (2) step();
    wcfg(4'b0010, 32'h0);   // re-enable -> assert
    repeat (2) step();
    irq_id = 4'b0000; repeat (2) step();

    // R1 events, w0 no effect, w1c
    ev_ur = 1; step(); ev_ur = 0;
    ev_ca = 1; ev_in_ca = 1; step(); ev_ca = 0; ev_in_ca = 0;
    wcfg(4'b1000, 32'h0);
    wcfg(4'b0111, 32'h3800_0000);     // lane 3 disabled: no clear
    wcfg(4'b1000, 32'h1000_0000);     // clear bit 28
    // R9 set wins
    step(); ev_ur = 1; cfg_wr = 1; cfg_be = 4'b1000; cfg_wdata = 32'h2000_0000;
    step(); ev_ur = 0; cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
    step();
    wcfg(4'b1000, 32'h3800_0000);

    // R7 R8 decode, mse off then on
    cmd(2'b01, 32'hA5C0_1234);
    wcfg(4'h1, 32'h2);
    cmd(2'b01, 32'hA5C0_1234);
    cmd(2'b10, 32'hA5FF_FFFC);
    cmd(2'b10, 32'hA600_0000);
    cmd(2'b11, 32'hA5C0_0000);
    cmd(2'b00, 32'hA5C0_0000);
    cmd(2'b01, 32'h25C0_0000);
    in_valid = 0; cmd(2'b01, 32'hA5C0_0010);
    in_valid = 0; in_cmd = 0;
    bar_base = 32'h0040_0000;
    cmd(2'b10, 32'h007F_FFFF);
    in_valid = 0;
    repeat (3) step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule